// File: doc/BRIEF.md
# Conversion Clock Source Selector

This block sets the pace of a converter's conversion logic. It runs on the free-running internal clock. It also watches an optional external clock pin. When the pin toggles steadily, the conversion pace is half the external rate. When the pin sits at one level, or is left pulled high, the pace falls back to half the internal clock. The pace is not a generated clock. It is a one-cycle clock-enable pulse in the internal clock domain, so the downstream logic stays on a single clock.

The pin is brought into the internal domain through a two-flop synchronizer, and its rising edges are detected there. A detector counts edges that arrive close together. The external source is declared present only after a run of edges, each one within a timeout window of the one before. If no edge arrives within the window, the detector withdraws that declaration. Because of this, a newly applied external clock takes over only after a short detection delay.

The divide-by-two stage changes source only between enable periods. No enable pulse is ever made from a mix of two sources. Each enable pulse marks one complete period of the source that is active at that time.

Top module: `conv_clk_select`

## Requirements
- R1: While reset is held and in the first cycle after it, `conv_en` is 0 and `ext_active` is 0 (0 = internal source, 1 = external source).
- R2: With the internal source active, `conv_en` is a one-cycle pulse on every second internal clock cycle: exactly 10 pulses in any 20 consecutive cycles.
- R3: A pin held high for any length of time keeps the internal source: `ext_active` stays 0 and the pulse rate of R2 continues.
- R4: The pin passes through a two-flop synchronizer before edge detection. The external source is selected only after LOCK_EDGES (default 4) synchronized rising edges, each arriving within TIMEOUT (default 16) internal cycles of the previous one. After only two such edges, `ext_active` is still 0.
- R5: Rising edges spaced more than TIMEOUT cycles apart never select the external source, however many arrive.
- R6: With the external source active, `conv_en` pulses once for every two synchronized rising edges of the pin: 10 pulses while 20 external periods pass.
- R7: With the external source active, if no rising edge is seen for TIMEOUT cycles, the selector returns to the internal source. This holds whether the pin stops high or stops low. The R2 pulse rate then resumes.
- R8: `conv_en` is never high in two consecutive cycles. It is 0 in the cycle in which `ext_active` changes. After any switch, the first pulse comes only after two ticks of the new source. A switch to external waits for an enable-period boundary. A switch back to internal drops the unfinished external half-period and emits no pulse for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock; all state is in this domain |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| ext_clk_pin | input | 1 | External clock pin, asynchronous; idles high |
| conv_en | output | 1 | One-cycle conversion clock-enable at half the selected source rate |
| ext_active | output | 1 | 1 when the external source drives `conv_en`, 0 for the internal source |

## Verification
Both outputs are registered. In internal mode, a pulse pattern is due from the second cycle after reset or after a switch. A pin rising edge reaches the detector two to three cycles after it happens. Selection is due about LOCK_EDGES pin periods later, and a return to internal is due about TIMEOUT plus four cycles after the last edge. The bench therefore samples on the falling clock edge. It checks levels only after margins that cover these latencies, and it checks pulse rates by counting over windows that are exact multiples of the source period.

// File: rtl/clksel_pkg.sv
package clksel_pkg;

    typedef enum logic {
        SRC_INT = 1'b0,
        SRC_EXT = 1'b1
    } src_e;

    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_st_t;

endpackage

// File: rtl/pin_sync.sv
module pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o
);
    import clksel_pkg::*;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{s1: 1'b1, s2: 1'b1, s3: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign rise_o = st_q.s2 & ~st_q.s3;

    // R4: an edge pulse never lasts two cycles
    p_rise_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);

endmodule

// File: rtl/activity_detect.sv
module activity_detect #(
    parameter int TIMEOUT    = 16,
    parameter int LOCK_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    output logic present_o
);
    localparam int GW = $clog2(TIMEOUT + 1);
    localparam int EW = $clog2(LOCK_EDGES + 1);

    typedef struct packed {
        logic [GW-1:0] gap;
        logic [EW-1:0] edges;
        logic          present;
    } det_st_t;

    det_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rise_i) begin
            st_d.gap = '0;
            if (int'(st_q.edges) < LOCK_EDGES) begin
                st_d.edges = st_q.edges + 1'b1;
            end
            if (int'(st_q.edges) + 1 >= LOCK_EDGES) begin
                st_d.present = 1'b1;
            end
        end else if (int'(st_q.gap) >= TIMEOUT) begin
            st_d.edges   = '0;
            st_d.present = 1'b0;
        end else begin
            st_d.gap = st_q.gap + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign present_o = st_q.present;

    // R4: presence is only ever declared on the back of an edge
    p_lock_on_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.present) |-> $past(rise_i));

    // R7: presence is only withdrawn while edges are absent
    p_drop_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.present) |-> !$past(rise_i));

    // R4: the run counter stays within its bound
    p_edge_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.edges) <= LOCK_EDGES);

endmodule

// File: rtl/enable_divider.sv
module enable_divider (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_ok_i,
    input  logic ext_rise_i,
    output logic en_o,
    output logic sel_ext_o
);
    import clksel_pkg::*;

    typedef struct packed {
        src_e sel;
        logic phase;
        logic en;
    } div_st_t;

    div_st_t st_d, st_q;
    src_e    want;
    logic    tick;

    always_comb begin
        want = ext_ok_i ? SRC_EXT : SRC_INT;
        tick = (st_q.sel == SRC_EXT) ? ext_rise_i : 1'b1;
        st_d    = st_q;
        st_d.en = 1'b0;
        if ((want != st_q.sel) && (!st_q.phase || want == SRC_INT)) begin
            st_d.sel   = want;
            st_d.phase = 1'b0;
        end else if (tick) begin
            st_d.phase = ~st_q.phase;
            st_d.en    = st_q.phase;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{sel: SRC_INT, phase: 1'b0, en: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign en_o      = st_q.en;
    assign sel_ext_o = (st_q.sel == SRC_EXT);

    // R8: no two enables back to back
    p_no_back_to_back_r8: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o);

    // R8: the cycle that shows a new source carries no enable
    p_switch_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext_o != $past(sel_ext_o)) |-> !en_o);

    // R8: a switch is never followed at once by an enable
    p_switch_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ext_o != $past(sel_ext_o)) |=> !en_o);

endmodule

// File: rtl/conv_clk_select.sv
module conv_clk_select #(
    parameter int TIMEOUT    = 16,
    parameter int LOCK_EDGES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_clk_pin,
    output logic conv_en,
    output logic ext_active
);
    logic pin_rise;
    logic ext_ok;

    pin_sync u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (ext_clk_pin),
        .rise_o (pin_rise)
    );

    activity_detect #(
        .TIMEOUT    (TIMEOUT),
        .LOCK_EDGES (LOCK_EDGES)
    ) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_i    (pin_rise),
        .present_o (ext_ok)
    );

    enable_divider u_div (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_ok_i   (ext_ok),
        .ext_rise_i (pin_rise),
        .en_o       (conv_en),
        .sel_ext_o  (ext_active)
    );

    // R1: both outputs sit low in the first cycle out of reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!conv_en && !ext_active));

endmodule

// File: tb/sim_conv_clk_select.sv
module sim_conv_clk_select;
    localparam int CLK_P   = 10;
    localparam int TO      = 16;
    localparam int NLOCK   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b1;
    logic conv_en;
    logic ext_active;

    int n_chk = 0;
    int n_bad = 0;
    int b2b_viol = 0;
    int sw_viol = 0;
    logic prev_en = 1'b0;
    logic prev_act = 1'b0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    conv_clk_select #(.TIMEOUT(TO), .LOCK_EDGES(NLOCK)) u0 (
        .clk(clk), .rst_n(rst_n), .ext_clk_pin(pin),
        .conv_en(conv_en), .ext_active(ext_active)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_en && conv_en) b2b_viol++;
            if ((prev_act != ext_active) && conv_en) sw_viol++;
        end
        prev_en  = conv_en;
        prev_act = ext_active;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic count_en(input int cycles, output int cnt);
        cnt = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (conv_en) cnt++;
        end
    endtask

    task automatic pulses(input int n, input int half);
        for (int i = 0; i < n; i++) begin
            repeat (half) @(negedge clk);
            pin = 1'b0;
            repeat (half) @(negedge clk);
            pin = 1'b1;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 en in reset", conv_en, 0);
        check("R1 source in reset", ext_active, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 en after reset", conv_en, 0);
    endtask

    task automatic t_internal();
        int c;
        repeat (2) @(negedge clk);
        count_en(20, c);
        check("R2 internal pulses per 20", c, 10);
    endtask

    task automatic t_static_high();
        int c;
        pin = 1'b1;
        count_en(100, c);
        check("R3 pulses with pin high", c, 50);
        check("R3 source with pin high", ext_active, 0);
    endtask

    task automatic t_slow();
        pulses(8, 20);
        repeat (4) @(negedge clk);
        check("R5 slow edges", ext_active, 0);
    endtask

    task automatic t_lock();
        pulses(2, 3);
        repeat (3) @(negedge clk);
        check("R4 two edges only", ext_active, 0);
        pulses(6, 3);
        repeat (4) @(negedge clk);
        check("R4 locked", ext_active, 1);
    endtask

    task automatic t_ext_rate();
        int c;
        fork
            pulses(24, 3);
            begin
                repeat (12) @(negedge clk);
                count_en(120, c);
            end
        join
        check("R6 ext pulses per 20 periods", c, 10);
    endtask

    task automatic t_revert_high();
        int c;
        pin = 1'b1;
        repeat (TO + 14) @(negedge clk);
        check("R7 revert pin high", ext_active, 0);
        count_en(20, c);
        check("R7 internal rate resumes", c, 10);
    endtask

    task automatic t_revert_low();
        pulses(8, 3);
        repeat (4) @(negedge clk);
        check("R7 relock", ext_active, 1);
        pin = 1'b0;
        repeat (TO + 14) @(negedge clk);
        check("R7 revert pin low", ext_active, 0);
        pin = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_internal();
        t_static_high();
        t_slow();
        t_lock();
        t_ext_rate();
        t_revert_high();
        t_revert_low();
        check("R8 back-to-back enables", b2b_viol, 0);
        check("R8 enable in switch cycle", sw_viol, 0);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 50000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule